// File: doc/BRIEF.md
# Configurable-Mode SPI Word Shifter

This block is the shifting engine of an SPI master. A one-cycle start pulse launches a transfer of one word whose length can be anything from 1 to the full register width (32 bits by default). Bits go out on the serial data output most significant bit first. At the same time, bits coming back on the serial data input are gathered into a received word. The transfer runs in any of the four clock modes, which are chosen by a polarity input and a phase input. The length of each serial-clock half-period comes from a delay count.

Every transfer can also be made transmit-only or receive-only. With the transmit-suppress flag set, the data output stays frozen. With the receive-suppress flag set, zeros are shifted in instead of line samples. All transfer settings are captured when the start pulse is accepted, so the controlling logic may change them while a word is in flight. Chip-select handling is left to the surrounding logic.

Top module: `spi_word_shifter`

## Requirements
- R1: The transfer length N equals `bit_len` for values 1 to W-1, and a `bit_len` of 0 selects N = W (W = 32). Each transfer produces exactly N idle-to-active SCLK transitions.
- R2: The k-th bit presented on `mosi` (k = 0 first) is `tx_word[N-1-k]`. Bits of `tx_word` at position N and above have no effect.
- R3: When `done` is high, `rx_word[N-1:0]` holds the N sampled `miso` bits, with the first sample in bit N-1. `rx_word` keeps that value until the next `done`.
- R4: While no transfer is running, `sclk` equals the `cpol` input, delayed by one cycle. In the cycle where `done` is high, `sclk` is at the captured polarity level.
- R5: With `cpha`=0, `mosi` changes only while `sclk` is at the idle level. `miso` is sampled at the clock edge where `sclk` goes from active back to idle.
- R6: With `cpha`=1, `mosi` changes at the same edge that drives `sclk` from idle to active. `miso` is sampled one half-period after `sclk` returns to idle.
- R7: Every SCLK half-period lasts `half_dly`+1 clock cycles, so 0 gives the fastest rate. `busy` is high for exactly N*2*(`half_dly`+1) cycles per transfer.
- R8: `done` is a single-cycle pulse. `busy` falls in the cycle that `done` rises.
- R9: With `no_tx`=1, `mosi` keeps the level it had before the start pulse for the whole transfer.
- R10: With `no_rx`=1, `miso` is ignored and `rx_word[N-1:0]` reads as zero.
- R11: `tx_word`, `bit_len`, `cpol`, `cpha`, `no_tx`, `no_rx` and `half_dly` are captured when `start` is accepted. A `start` pulse while `busy` is high is ignored, and the transfer in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| tx_word | input | 32 | Word to send, right-justified |
| bit_len | input | 5 | Word length, 0 means 32 |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | Clock phase select |
| no_tx | input | 1 | Freeze mosi for this transfer |
| no_rx | input | 1 | Shift zeros instead of miso |
| half_dly | input | 8 | Extra cycles per SCLK half-period |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | 32 | Received word, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A fault in the half-period counter shows up as a wrong `busy` length by the end of the first transfer. It shows up even earlier as SCLK transitions that a bit-by-bit slave model counts as extra or missing. A misaligned or mis-shifting data register gives a wrong bit on `mosi` at the first slave sampling edge. It also gives a wrong `rx_word` at `done`. A wrong phase or polarity state surfaces within one bit time, as a `mosi` change during the active clock level or a sample taken from the wrong slave bit.

// File: rtl/spi_ws_pkg.sv
package spi_ws_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic no_tx;
    logic no_rx;
  } ws_mode_t;
endpackage

// File: rtl/spi_ws_timer.sv
module spi_ws_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first,
  input  logic             load,
  input  logic [DLY_W-1:0] dly_in,
  output logic             expired
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dly_q <= '0;
    end else if (first) begin
      cnt_q <= dly_in;
      dly_q <= dly_in;
    end else if (load) begin
      cnt_q <= dly_q;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - DLY_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

  // R7: between reloads, the count falls by one per cycle
  a_r7_count_down: assert property (@(posedge clk) disable iff (rst)
    (!first && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DLY_W'(1)));
endmodule

// File: rtl/spi_ws_shreg.sv
module spi_ws_shreg #(
  parameter int W     = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic [W-1:0]     din,
  input  logic             shift,
  input  logic             sin,
  output logic             first_bit,
  output logic [W-2:0]     q_low
);
  localparam logic [CNT_W-1:0] W_C = CNT_W'(W);

  logic [W-1:0] reg_q;
  logic [W-1:0] aligned;

  always_comb begin
    aligned   = din << (W_C - len);
    first_bit = aligned[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst)        reg_q <= '0;
    else if (load)  reg_q <= aligned;
    else if (shift) reg_q <= {reg_q[W-2:0], sin};
  end

  assign q_low = reg_q[W-2:0];

  // R3: each shift moves the register up one place and enters the sample at bit 0
  a_r3_shift_in: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> (reg_q == {$past(reg_q[W-2:0]), $past(sin)}));
endmodule

// File: rtl/spi_ws_ctrl.sv
module spi_ws_ctrl
  import spi_ws_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  ws_mode_t         mode_in,
  input  logic [CNT_W-1:0] len,
  input  logic             tmr_expired,
  input  logic             first_bit,
  input  logic [W-2:0]     sreg_low,
  input  logic             miso,
  output logic             accept,
  output logic             tmr_load,
  output logic             sh_shift,
  output logic             sh_in,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  output logic [W-1:0]     rx_word
);
  ws_mode_t         mode_q;
  logic             phase_q;
  logic [CNT_W-1:0] bits_q;

  always_comb begin
    accept   = start && !busy;
    tmr_load = busy && tmr_expired;
    sh_shift = busy && tmr_expired && phase_q;
    sh_in    = mode_q.no_rx ? 1'b0 : miso;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      phase_q <= 1'b0;
      bits_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        mode_q  <= mode_in;
        busy    <= 1'b1;
        phase_q <= 1'b0;
        bits_q  <= len;
        sclk    <= mode_in.cpha ? ~mode_in.cpol : mode_in.cpol;
        if (!mode_in.no_tx) mosi <= first_bit;
      end else if (busy && tmr_expired) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
          sclk    <= mode_q.cpha ? mode_q.cpol : ~mode_q.cpol;
        end else begin
          bits_q <= bits_q - CNT_W'(1);
          if (bits_q == CNT_W'(1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            sclk    <= mode_q.cpol;
            rx_word <= {sreg_low, sh_in};
          end else begin
            phase_q <= 1'b0;
            sclk    <= mode_q.cpha ? ~mode_q.cpol : mode_q.cpol;
            if (!mode_q.no_tx) mosi <= sreg_low[W-2];
          end
        end
      end else if (!busy) begin
        sclk <= mode_in.cpol;
      end
    end
  end

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: busy only falls together with done
  a_r8_fall_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R4: serial clock is back at the idle level on completion
  a_r4_idle_at_end: assert property (@(posedge clk) disable iff (rst)
    done |-> (sclk == mode_q.cpol));
  // R7: serial clock holds while the half-period counter runs
  a_r7_half_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !tmr_expired) |=> $stable(sclk));
  // R9: data output frozen for a transmit-suppressed transfer
  a_r9_tx_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q.no_tx) |=> (!busy || $stable(mosi)));
  // R11: a start while busy leaves the captured settings alone
  a_r11_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mode_q));
  // R1: a running transfer always has bits left
  a_r1_bits_left: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bits_q != '0));
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_ws_pkg::*;
#(
  parameter int W     = 32,
  parameter int LW    = $clog2(W),
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     tx_word,
  input  logic [LW-1:0]    bit_len,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             no_tx,
  input  logic             no_rx,
  input  logic [DLY_W-1:0] half_dly,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_word,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  localparam int CNT_W = LW + 1;
  localparam logic [CNT_W-1:0] W_C = CNT_W'(W);

  ws_mode_t         mode_in;
  logic [CNT_W-1:0] len_eff;
  logic             accept;
  logic             tmr_load;
  logic             tmr_expired;
  logic             sh_shift;
  logic             sh_in;
  logic             first_bit;
  logic [W-2:0]     sreg_low;

  always_comb begin
    mode_in = '{cpol: cpol, cpha: cpha, no_tx: no_tx, no_rx: no_rx};
    len_eff = (bit_len == '0) ? W_C : {1'b0, bit_len};
  end

  spi_ws_timer #(.DLY_W(DLY_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .first   (accept),
    .load    (tmr_load),
    .dly_in  (half_dly),
    .expired (tmr_expired)
  );

  spi_ws_shreg #(.W(W), .CNT_W(CNT_W)) u_shreg (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .len       (len_eff),
    .din       (tx_word),
    .shift     (sh_shift),
    .sin       (sh_in),
    .first_bit (first_bit),
    .q_low     (sreg_low)
  );

  spi_ws_ctrl #(.W(W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mode_in     (mode_in),
    .len         (len_eff),
    .tmr_expired (tmr_expired),
    .first_bit   (first_bit),
    .sreg_low    (sreg_low),
    .miso        (miso),
    .accept      (accept),
    .tmr_load    (tmr_load),
    .sh_shift    (sh_shift),
    .sh_in       (sh_in),
    .busy        (busy),
    .done        (done),
    .sclk        (sclk),
    .mosi        (mosi),
    .rx_word     (rx_word)
  );
endmodule

// File: tb/spi_word_shifter_test.sv
module spi_word_shifter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] tx_word;
  logic [4:0]  bit_len;
  logic        cpol, cpha, no_tx, no_rx;
  logic [7:0]  half_dly;
  logic        busy, done, sclk, mosi, miso;
  logic [31:0] rx_word;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  spi_word_shifter uut (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .bit_len(bit_len),
    .cpol(cpol), .cpha(cpha), .no_tx(no_tx), .no_rx(no_rx), .half_dly(half_dly),
    .busy(busy), .done(done), .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic logic [31:0] len_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input logic [4:0] bl, input logic cp,
                      input logic ph, input logic ntx, input logic nrx,
                      input logic [7:0] d, input logic [31:0] sw, input bit inject,
                      input string tag);
    int n, cyc, edges, sidx, mchg, bad_setup, dcount;
    logic [31:0] got, msk, exp_tx, exp_rx, rx_hold;
    logic prev, cur, mo, prev_mo, m0, sclk_end;
    n = (bl == 5'd0) ? 32 : int'(bl);
    msk = len_mask(n);
    tx_word = tx; bit_len = bl; cpol = cp; cpha = ph;
    no_tx = ntx; no_rx = nrx; half_dly = d; start = 1'b0;
    miso = (ph == 1'b0) ? sw[n-1] : 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == cp, {tag, " R4 idle level"}, sclk, cp);
    m0 = mosi; prev = sclk; prev_mo = mosi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tx_word = ~tx;            // R11: later changes must not matter
    half_dly = d + 8'd3;
    cyc = 0; edges = 0; sidx = 0; mchg = 0; bad_setup = 0; dcount = 0;
    got = '0; sclk_end = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      cur = sclk; mo = mosi;
      if (busy) cyc++;
      if (mo != prev_mo) begin
        mchg++;
        if (ph == 1'b0 && cur != cp) bad_setup++;
      end
      if (prev == cp && cur != cp) begin
        edges++;
        if (ph == 1'b0) got = {got[30:0], mo};
        else begin
          if (sidx < n) miso = sw[n-1-sidx];
          sidx++;
        end
      end
      if (prev != cp && cur == cp) begin
        if (ph == 1'b0) begin
          sidx++;
          if (sidx < n) miso = sw[n-1-sidx];
        end else got = {got[30:0], mo};
      end
      prev = cur; prev_mo = mo;
      if (done) begin
        dcount++;
        sclk_end = sclk;
        chk(!busy, {tag, " R8 busy low with done"}, busy, 0);
        break;
      end
      if (inject && cyc == 3) begin
        start = 1'b1; bit_len = bl + 5'd3; cpha = ~ph; no_rx = ~nrx; no_tx = ~ntx;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    exp_tx = ntx ? (m0 ? msk : 32'h0) : (tx & msk);
    exp_rx = nrx ? 32'h0 : (sw & msk);
    chk(dcount == 1, {tag, " R8 done seen"}, dcount, 1);
    chk(edges == n, {tag, " R1 active edges"}, edges, n);
    chk((got & msk) == exp_tx, {tag, ntx ? " R9 frozen mosi" : " R2 mosi bits"}, got & msk, exp_tx);
    if (ntx) chk(mchg == 0, {tag, " R9 mosi changes"}, mchg, 0);
    chk((rx_word & msk) == exp_rx,
        {tag, nrx ? " R10 zero rx" : (ph ? " R6/R3 rx word" : " R5/R3 rx word")},
        rx_word & msk, exp_rx);
    if (ph == 1'b0) chk(bad_setup == 0, {tag, " R5 mosi change while active"}, bad_setup, 0);
    chk(cyc == n * 2 * (int'(d) + 1), {tag, " R7 busy cycles"}, cyc, n * 2 * (int'(d) + 1));
    chk(sclk_end == cp, {tag, " R4 level at done"}, sclk_end, cp);
    rx_hold = rx_word;
    @(negedge clk);
    chk(!done, {tag, " R8 single pulse"}, done, 0);
    chk(rx_word == rx_hold, {tag, " R3 rx held"}, rx_word, rx_hold);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h51C0_0DE5));
    rst = 1'b1; start = 1'b0; tx_word = '0; bit_len = '0; cpol = 1'b0; cpha = 1'b0;
    no_tx = 1'b0; no_rx = 1'b0; half_dly = '0; miso = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R8 reset idle", {busy, done}, 0);
    chk(rx_word == 32'h0, "R3 reset rx", rx_word, 0);
    chk(sclk == 1'b0, "R4 reset sclk", sclk, 0);

    // directed corners: all modes, length 0 (=32) and 1, fastest and slow rates
    xfer(32'hA5C3_0F96, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 32'h3C5A_F00F, 1'b0, "R1 len32 m0");
    xfer(32'h0000_0001, 5'd1,  1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 32'h0000_0001, 1'b0, "len1 m3");
    xfer(32'hFFFF_FF5A, 5'd8,  1'b0, 1'b1, 1'b0, 1'b0, 8'd2, 32'h0000_00C3, 1'b0, "R2 upper ignored m1");
    xfer(32'h0000_1234, 5'd16, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 32'h0000_BEEF, 1'b0, "m2");
    xfer(32'h0000_00FF, 5'd12, 1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 32'h0000_0ABC, 1'b0, "R9 notx");
    xfer(32'h0000_0F0F, 5'd12, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0, 32'h0000_0FFF, 1'b0, "R10 norx");
    xfer(32'h0000_5A5A, 5'd16, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 32'h0000_9669, 1'b1, "R11 start while busy");
    xfer(32'h0000_0333, 5'd10, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2, 32'h0000_02AA, 1'b1, "R11 inject m3");

    for (int t = 0; t < 40; t++) begin
      xfer($urandom, 5'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 6) == 0, ($urandom % 6) == 0, 8'($urandom % 4), $urandom,
           1'b0, "random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule